// File: doc/BRIEF.md
# Multi-bank programmable clock divider

This block turns one fast clock into three banks of four divided clocks plus one feedback clock. Each of the four dividers takes its ratio from a small select code. A shared range bit either uses every tick of the chosen clock or halves the rate first, which doubles every ratio. The block runs on a single system clock `clk`. The source clock and the alternate reference clock arrive as one-cycle tick strobes (`src_tick`, `ref_tick`), one strobe for each rising edge of the clock it stands for. `use_src` chooses which strobe drives the dividers.

All divided clocks have a 50% duty cycle. After reset they start in phase, so every divider's first rising edge falls on the same tick. Any of the twelve bank outputs can be held low through a stop mask. A stop or a restart only takes effect while that output is low, so no output ever shows a shortened high phase. The upper half of bank C can be inverted. `q_sync` marks the rising edges where bank A and bank C rise together and stays high for one bank A period.

All pins are plain control and clock-level signals. No data stream crosses the block's edge, so it has no valid/ready interface and no back-pressure. The range bit, the select codes and the inversion select are static settings: change them only while `rst_n` is low.

Top module: `clkdiv_banks`

## Requirements
- R1: When `range_hi` is 1, every selected tick advances the dividers. When it is 0, only every second selected tick counts: the first counting tick is the second one after reset, and every ratio doubles.
- R2: With `range_hi`=1, `q_a` has a period of 4, 6, 8 or 12 selected ticks for `sel_a` = 0, 1, 2 or 3.
- R3: With `range_hi`=1, `q_b` has a period of 4, 6, 8 or 10 ticks for `sel_b` = 0 to 3.
- R4: With `range_hi`=1, `q_c` has a period of 2, 4, 6 or 8 ticks for `sel_c` = 0 to 3.
- R5: With `range_hi`=1, `q_fb` has a period of 4, 6, 8, 10, 8, 12, 16 or 20 ticks for `sel_fb` = 0 to 7.
- R6: When `inv_c` is 1, `q_c[3:2]` are the inverse of the bank C clock, while `q_c[1:0]` stay true. When `inv_c` is 0, all four are in phase.
- R7: When `use_src` is 1, `src_tick` drives the dividers and `ref_tick` is ignored. When `use_src` is 0, the roles are swapped.
- R8: While `rst_n` is 0, every output is 0. After release, the first counting tick drives every divided clock high together, and the outputs change on the `clk` edge that samples the tick.
- R9: Stop mask bits 3:0 map to `q_a[3:0]`, bits 7:4 to `q_b[3:0]` and bits 11:8 to `q_c[3:0]`. An output whose bit is 1 stays low.
- R10: A stop bit is taken in only on edges where that output's underlying clock is low. A stop or a restart therefore never shortens a high phase.
- R11: Each divided clock is high for exactly half its period and low for the other half.
- R12: `q_sync` rises at a bank A rising edge that coincides with a bank C rising edge and holds for one bank A period. At any other bank A rising edge it goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | Strobe for each rising edge of the source clock |
| ref_tick | input | 1 | Strobe for each rising edge of the alternate reference clock |
| use_src | input | 1 | 1: source ticks drive the dividers, 0: reference ticks |
| range_hi | input | 1 | 1: no prescale, 0: divide by 2 first |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_c | input | 2 | Bank C ratio code |
| sel_fb | input | 3 | Feedback ratio code |
| inv_c | input | 1 | Invert the upper half of bank C |
| stop_mask | input | 12 | Per-output stop bits, 1 = hold low |
| q_a | output | 4 | Bank A clocks |
| q_b | output | 4 | Bank B clocks |
| q_c | output | 4 | Bank C clocks |
| q_fb | output | 1 | Feedback clock |
| q_sync | output | 1 | Coincident A/C rising-edge marker |

## Verification
The first pattern drives a tick on every cycle at full range. This exposes an off-by-one in any ratio table entry, because each period length shows up at once. Halved range with sparse random ticks separates the prescaler's phase from the divider counts, and the reference-select runs show whether the unselected strobe leaks into the dividers. Random stop-mask changes made at arbitrary points of each output's waveform tell correct low-phase gating apart from gating that cuts a high phase short. Random pairs of bank A and C codes give coincidence patterns where the sync marker must track different least-common-multiple periods.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int OUTS_PER_BANK = 4;
  localparam int NUM_DIVS      = 4;
  localparam int CODE_W        = 3;
  localparam int HALF_W        = 4;

  typedef enum logic [1:0] {
    DIV_A  = 2'd0,
    DIV_B  = 2'd1,
    DIV_C  = 2'd2,
    DIV_FB = 2'd3
  } div_kind_e;

  // Half period, in counting ticks, for each divider and code.
  function automatic logic [HALF_W-1:0] half_count(div_kind_e kind, logic [CODE_W-1:0] code);
    logic [HALF_W-1:0] h;
    case (kind)
      DIV_A: case (code[1:0])
        2'd0: h = HALF_W'(2);
        2'd1: h = HALF_W'(3);
        2'd2: h = HALF_W'(4);
        default: h = HALF_W'(6);
      endcase
      DIV_B: case (code[1:0])
        2'd0: h = HALF_W'(2);
        2'd1: h = HALF_W'(3);
        2'd2: h = HALF_W'(4);
        default: h = HALF_W'(5);
      endcase
      DIV_C: h = HALF_W'(code[1:0]) + HALF_W'(1);
      default: case (code)
        3'd0: h = HALF_W'(2);
        3'd1: h = HALF_W'(3);
        3'd2: h = HALF_W'(4);
        3'd3: h = HALF_W'(5);
        3'd4: h = HALF_W'(4);
        3'd5: h = HALF_W'(6);
        3'd6: h = HALF_W'(8);
        default: h = HALF_W'(10);
      endcase
    endcase
    return h;
  endfunction
endpackage

// File: rtl/clkdiv_prescale.sv
module clkdiv_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic range_hi,
  output logic base_tick
);
  logic odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       odd_q <= 1'b0;
    else if (tick_in) odd_q <= ~odd_q;
  end

  // Full range passes every tick; halved range passes every second one.
  assign base_tick = tick_in & (range_hi | odd_q);
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
#(
  parameter div_kind_e KIND = DIV_A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic [CODE_W-1:0] code,
  output logic              phase,
  output logic              rise_now
);
  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] reload;

  assign reload = half_count(KIND, code) - HALF_W'(1);

  // Toggle on the first counting tick, then every half period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (base_tick) begin
      if (cnt_q == '0) begin
        phase <= ~phase;
        cnt_q <= reload;
      end else begin
        cnt_q <= cnt_q - HALF_W'(1);
      end
    end
  end

  assign rise_now = base_tick & (cnt_q == '0) & ~phase;
endmodule

// File: rtl/clkdiv_stop_gate.sv
module clkdiv_stop_gate #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] clk_in,
  input  logic [N-1:0] stop,
  output logic [N-1:0] q_out
);
  logic [N-1:0] run_q;

  // A run bit only reloads while its clock is low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!clk_in[i]) run_q[i] <= ~stop[i];
      end
    end
  end

  assign q_out = clk_in & run_q;
endmodule

// File: rtl/clkdiv_banks.sv
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int OUTS = OUTS_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              ref_tick,
  input  logic              use_src,
  input  logic              range_hi,
  input  logic [1:0]        sel_a,
  input  logic [1:0]        sel_b,
  input  logic [1:0]        sel_c,
  input  logic [2:0]        sel_fb,
  input  logic              inv_c,
  input  logic [3*OUTS-1:0] stop_mask,
  output logic [OUTS-1:0]   q_a,
  output logic [OUTS-1:0]   q_b,
  output logic [OUTS-1:0]   q_c,
  output logic              q_fb,
  output logic              q_sync
);
  localparam int NOUT      = 3 * OUTS;
  localparam int HALF_OUTS = OUTS / 2;

  logic                             sel_tick;
  logic                             base_tick;
  logic [NUM_DIVS-1:0][CODE_W-1:0]  codes;
  logic [NUM_DIVS-1:0]              phase_v;
  logic [NUM_DIVS-1:0]              rise_v;
  logic [OUTS-1:0]                  c_vec;
  logic [NOUT-1:0]                  pre_gate;
  logic [NOUT-1:0]                  gated;

  assign sel_tick = use_src ? src_tick : ref_tick;

  clkdiv_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (sel_tick),
    .range_hi  (range_hi),
    .base_tick (base_tick)
  );

  assign codes[int'(DIV_A)]  = {1'b0, sel_a};
  assign codes[int'(DIV_B)]  = {1'b0, sel_b};
  assign codes[int'(DIV_C)]  = {1'b0, sel_c};
  assign codes[int'(DIV_FB)] = sel_fb;

  for (genvar g = 0; g < NUM_DIVS; g++) begin : g_div
    clkdiv_counter #(.KIND(div_kind_e'(g))) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .code      (codes[g]),
      .phase     (phase_v[g]),
      .rise_now  (rise_v[g])
    );
  end

  for (genvar j = 0; j < OUTS; j++) begin : g_cvec
    if (j >= OUTS - HALF_OUTS) begin : g_inv
      assign c_vec[j] = phase_v[int'(DIV_C)] ^ inv_c;
    end else begin : g_true
      assign c_vec[j] = phase_v[int'(DIV_C)];
    end
  end

  assign pre_gate = {c_vec, {OUTS{phase_v[int'(DIV_B)]}}, {OUTS{phase_v[int'(DIV_A)]}}};

  clkdiv_stop_gate #(.N(NOUT)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_in (pre_gate),
    .stop   (stop_mask),
    .q_out  (gated)
  );

  assign q_a  = gated[OUTS-1:0];
  assign q_b  = gated[2*OUTS-1:OUTS];
  assign q_c  = gated[3*OUTS-1:2*OUTS];
  assign q_fb = phase_v[int'(DIV_FB)];

  // Sync marker is re-decided at every bank A rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     q_sync <= 1'b0;
    else if (rise_v[int'(DIV_A)])   q_sync <= rise_v[int'(DIV_C)];
  end
endmodule

// File: rtl/clkdiv_banks_chk.sv
module clkdiv_banks_chk
  import clkdiv_pkg::*;
#(
  parameter int OUTS = OUTS_PER_BANK
) (
  input logic                clk,
  input logic                rst_n,
  input logic                src_tick,
  input logic                ref_tick,
  input logic                use_src,
  input logic                inv_c,
  input logic [OUTS-1:0]     q_a,
  input logic [OUTS-1:0]     q_c,
  input logic                q_sync,
  input logic [NUM_DIVS-1:0] phase_v,
  input logic [NUM_DIVS-1:0] rise_v
);
  localparam int HALF_OUTS = OUTS / 2;

  for (genvar i = 0; i < OUTS; i++) begin : g_a
    p_a_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q_a[i]) |-> $rose(phase_v[0]));
    p_a_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q_a[i]) |-> $fell(phase_v[0]));
  end

  for (genvar j = 0; j < OUTS; j++) begin : g_c
    if (j < OUTS - HALF_OUTS) begin : g_true
      p_c_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_c[j]) |-> $rose(phase_v[2]));
    end else begin : g_inv
      p_c_inv_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_c && $stable(inv_c) && $rose(q_c[j])) |-> $fell(phase_v[2]));
      p_c_true_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv_c && $stable(inv_c) && $rose(q_c[j])) |-> $rose(phase_v[2]));
    end
  end

  for (genvar g = 0; g < NUM_DIVS; g++) begin : g_rise
    p_rise_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rise_v[g] |=> $rose(phase_v[g]));
  end

  p_sync_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_sync) |-> ($rose(phase_v[0]) && $rose(phase_v[2])));

  p_idle_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_src && !src_tick) |=> $stable(phase_v));
  p_idle_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_src && !ref_tick) |=> $stable(phase_v));
endmodule

bind clkdiv_banks clkdiv_banks_chk #(.OUTS(OUTS)) u_chk (.*);

// File: tb/tb_clkdiv_banks.sv
module tb_clkdiv_banks;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_tick = 1'b0, ref_tick = 1'b0, use_src = 1'b1, range_hi = 1'b1;
  logic [1:0]  sel_a = '0, sel_b = '0, sel_c = '0;
  logic [2:0]  sel_fb = '0;
  logic        inv_c = 1'b0;
  logic [11:0] stop_mask = '0;
  logic [3:0]  q_a, q_b, q_c;
  logic        q_fb, q_sync;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string seg_tag = "";

  // Reference model state
  int          last_idx;
  bit [11:0]   en_m;
  bit          sync_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_banks dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ref_tick(ref_tick),
    .use_src(use_src), .range_hi(range_hi), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .sel_fb(sel_fb), .inv_c(inv_c), .stop_mask(stop_mask),
    .q_a(q_a), .q_b(q_b), .q_c(q_c), .q_fb(q_fb), .q_sync(q_sync)
  );

  // Full period in selected ticks (R1..R5)
  function automatic int ratio(int kind, int code);
    int r;
    case (kind)
      0: r = (code == 0) ? 4 : (code == 1) ? 6 : (code == 2) ? 8 : 12;
      1: r = 4 + 2 * code;
      2: r = 2 + 2 * code;
      default: begin
        int fb_tab[8] = '{4, 6, 8, 10, 8, 12, 16, 20};
        r = fb_tab[code];
      end
    endcase
    return range_hi ? r : 2 * r;
  endfunction

  function automatic int first_idx();
    return range_hi ? 0 : 1;
  endfunction

  function automatic bit level(int r);
    if (last_idx < first_idx()) return 1'b0;
    return (((last_idx - first_idx()) / (r / 2)) % 2) == 0;
  endfunction

  function automatic bit [11:0] raw_vec();
    bit a, b, c;
    a = level(ratio(0, int'(sel_a)));
    b = level(ratio(1, int'(sel_b)));
    c = level(ratio(2, int'(sel_c)));
    return {{2{c ^ inv_c}}, {2{c}}, {4{b}}, {4{a}}};
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    last_idx = -1;
    en_m     = '0;
    sync_m   = 1'b0;
  endtask

  task automatic model_edge();
    bit [11:0] old;
    int ra, rc;
    old = raw_vec();
    for (int i = 0; i < 12; i++) if (!old[i]) en_m[i] = !stop_mask[i];
    if (use_src ? src_tick : ref_tick) begin
      last_idx++;
      ra = ratio(0, int'(sel_a));
      rc = ratio(2, int'(sel_c));
      if (last_idx >= first_idx() && ((last_idx - first_idx()) % ra) == 0)
        sync_m = ((last_idx - first_idx()) % rc) == 0;
    end
  endtask

  task automatic compare();
    bit [11:0] e;
    e = raw_vec() & en_m;
    check({seg_tag, " R2 R9 R10 R11 bank A"}, int'(q_a), int'(e[3:0]));
    check({seg_tag, " R3 R9 R10 bank B"}, int'(q_b), int'(e[7:4]));
    check({seg_tag, " R4 R6 R9 bank C"}, int'(q_c), int'(e[11:8]));
    check({seg_tag, " R5 feedback"}, int'(q_fb), int'(level(ratio(3, int'(sel_fb)))));
    check({seg_tag, " R12 sync"}, int'(q_sync), int'(sync_m));
  endtask

  task automatic run(int n, int src_p, int ref_p, int stop_p);
    for (int k = 0; k < n; k++) begin
      src_tick = $urandom_range(99) < src_p;
      ref_tick = $urandom_range(99) < ref_p;
      if ($urandom_range(99) < stop_p) stop_mask = 12'($urandom);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic segment(string tag, bit rh, bit us, int a, int b, int c, int fb, bit inv,
                         logic [11:0] stop);
    @(negedge clk);
    rst_n = 1'b0;
    seg_tag = tag;
    range_hi = rh; use_src = us; sel_a = 2'(a); sel_b = 2'(b); sel_c = 2'(c);
    sel_fb = 3'(fb); inv_c = inv; stop_mask = stop; src_tick = 1'b0; ref_tick = 1'b0;
    model_reset();
    #1;
    check("R8 outputs low in reset", int'({q_sync, q_fb, q_c, q_b, q_a}), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);

    // Directed: every ratio code at full rate
    for (int code = 0; code < 8; code++) begin
      segment("R2 R8 full-rate", 1'b1, 1'b1, code % 4, (code + 1) % 4, (code + 2) % 4, code,
              1'b0, 12'h000);
      run(100, 100, 0, 0);
    end
    // Directed: halved range
    segment("R1 halved", 1'b0, 1'b1, 3, 2, 1, 7, 1'b0, 12'h000);
    run(200, 100, 0, 0);
    // Directed: inversion
    segment("R6 inverted", 1'b1, 1'b1, 1, 1, 0, 2, 1'b1, 12'h000);
    run(150, 70, 0, 0);
    // Directed: everything stopped
    segment("R9 all-stopped", 1'b1, 1'b1, 0, 0, 0, 0, 1'b0, 12'hFFF);
    run(80, 100, 0, 0);
    check("R9 stopped banks stay low", int'({q_c, q_b, q_a}), 0);
    // Directed: reference selected, reference silent
    segment("R7 ref-silent", 1'b1, 1'b0, 0, 0, 0, 0, 1'b0, 12'h000);
    run(80, 100, 0, 0);
    check("R7 source ignored when reference selected", int'({q_fb, q_c, q_b, q_a}), 0);
    // Random configurations with random stops
    for (int s = 0; s < 12; s++) begin
      segment("R1 R7 R10 random", 1'($urandom), 1'($urandom), int'($urandom_range(3)),
              int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(7)),
              1'($urandom), 12'($urandom));
      run(300, int'($urandom_range(30, 100)), int'($urandom_range(30, 100)), 8);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule